// File: doc/BRIEF.md
# Gamma Curve Duty Fade Sequencer

This block drives the duty value of one PWM channel through a chain of up to sixteen linear ramps, so that together they approximate a gamma-shaped brightness curve. Each ramp is one 32-bit word in a small local parameter store that is written through a plain write port. A word gives four things: the direction of the ramp, the number of PWM periods to wait between steps, the step size and the number of steps.

To run a fade, set the number of table words to use and the starting duty, then strobe `startSet`. The engine counts the PWM-period ticks from the channel. It adds the step size to the duty, or subtracts it, when each interval ends. It moves to the next word when the current ramp is done. After the last word it keeps the final duty, drops its busy flag and pulses a done flag. Strobes can pause the fade at any point and resume it from the same place.

Top module: `gamma_fade_engine`

## Requirements
- R1: After reset, `dutyOut` is 0, `fadeBusy` is 0 and `fadeDone` is 0. While the engine is idle, `dutyOut` does not change.
- R2: A write stores `ramWrData` at `ramWrAddr`. In each word, bit 0 is the up/down flag, bits 10:1 are the interval in ticks, bits 20:11 are the step size, bits 30:21 are the step count, and bit 31 is unused. Strobing `startSet` loads `dutyInit` into `dutyOut` and sets `fadeBusy` at the next clock edge. A tick in that same cycle is ignored.
- R3: When the up/down flag is 1, the duty rises by the step size on the clock edge of every interval-th tick.
- R4: When the up/down flag is 0, the duty falls by the step size at each interval.
- R5: A word is finished after its step count of steps, and the next word then takes effect at once. A word with a step count of 0 takes one clock cycle and changes nothing.
- R6: Once all words are used, `fadeBusy` clears one cycle after the last step and `fadeDone` is high for exactly one cycle. The duty then keeps its final value, and later ticks have no effect.
- R7: A rising step stops at the largest value, 2^DUTY_W-1, and never wraps.
- R8: A falling step stops at 0 and never wraps.
- R9: After `pauseStb`, ticks are ignored and the duty holds. A tick in the same cycle as `pauseStb` is also ignored.
- R10: After `resumeStb`, the fade continues with its partial tick count and step count kept. A tick in the same cycle as `resumeStb` is counted.
- R11: If `entryCount` is 0, the fade ends one cycle after it starts and the duty stays at `dutyInit`.
- R12: An interval field of 0 means one tick per step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ramWrEn | input | 1 | Parameter store write enable |
| ramWrAddr | input | 4 | Parameter word index |
| ramWrData | input | 32 | Parameter word |
| entryCount | input | 5 | Number of words the fade uses (0 to 16) |
| dutyInit | input | 20 | Starting duty |
| startSet | input | 1 | Start strobe (sets the busy bit) |
| pauseStb | input | 1 | Pause strobe |
| resumeStb | input | 1 | Resume strobe |
| periodTick | input | 1 | One pulse per PWM period |
| dutyOut | output | 20 | Duty currently applied |
| fadeBusy | output | 1 | Fade in progress (start bit) |
| fadeDone | output | 1 | One-cycle pulse when the fade ends |

## Verification
A period tick can fall in the same cycle as a pause strobe or a resume strobe. The bench lines these up on purpose. It sends a tick in the very cycle the pause arrives and another tick with the resume. The result is judged from the duty that follows: the tick sent with the pause must not count, and the tick sent with the resume must count. The only sequence that shows both outcomes is the full set of tick counts needed before the next step appears.

// File: rtl/gfade_pkg.sv
package gfade_pkg;
  localparam int FIELD_W = 10;
  localparam int WORD_W  = 32;

  // Word layout from bit 0 upward: incr, cycles, scale, stepNum, reserved.
  typedef struct packed {
    logic               rsvd;
    logic [FIELD_W-1:0] stepNum;
    logic [FIELD_W-1:0] scale;
    logic [FIELD_W-1:0] cycles;
    logic               incr;
  } gfade_entry_t;

  // Strobes that the control sends to the duty datapath.
  typedef struct packed {
    logic               loadInit;
    logic               stepEn;
    logic               stepUp;
    logic [FIELD_W-1:0] stepSize;
  } gfade_strobe_t;
endpackage

// File: rtl/gfade_param_ram.sv
module gfade_param_ram
  import gfade_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output gfade_entry_t  rdEntry
);
  logic [WORD_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (wrEn) begin
      mem[wrAddr] <= wrData;
    end
  end

  assign rdEntry = gfade_entry_t'(mem[rdAddr]);
endmodule

// File: rtl/gfade_ctrl.sv
module gfade_ctrl
  import gfade_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int AW    = $clog2(ENTRIES),
  localparam int CNT_W = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] entryCount,
  input  logic             startSet,
  input  logic             pauseStb,
  input  logic             resumeStb,
  input  logic             periodTick,
  input  gfade_entry_t     entry,
  output logic [AW-1:0]    entryIdx,
  output gfade_strobe_t    strb,
  output logic             busy,
  output logic             done,
  output logic             paused
);
  logic [CNT_W-1:0]   idxQ;
  logic [FIELD_W-1:0] stepCntQ;
  logic [FIELD_W-1:0] tickCntQ;
  logic               busyQ, doneQ, pausedQ;

  logic [CNT_W-1:0]   effCount;
  logic [FIELD_W:0]   cycLimit;
  logic               active, lastEntry, zeroSteps, tickHit, stepFires;

  always_comb begin
    effCount  = (entryCount > CNT_W'(ENTRIES)) ? CNT_W'(ENTRIES) : entryCount;
    lastEntry = idxQ >= effCount;
    zeroSteps = entry.stepNum == '0;
    cycLimit  = (entry.cycles == '0) ? (FIELD_W+1)'(1) : {1'b0, entry.cycles};
    active    = busyQ && !pauseStb && (!pausedQ || resumeStb);
    tickHit   = periodTick && (({1'b0, tickCntQ} + 1'b1) >= cycLimit);
    stepFires = active && !lastEntry && !zeroSteps && tickHit && !startSet;

    strb          = '0;
    strb.loadInit = startSet;
    strb.stepEn   = stepFires;
    strb.stepUp   = entry.incr;
    strb.stepSize = entry.scale;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ     <= '0;
      stepCntQ <= '0;
      tickCntQ <= '0;
      busyQ    <= 1'b0;
      doneQ    <= 1'b0;
      pausedQ  <= 1'b0;
    end else if (startSet) begin
      idxQ     <= '0;
      stepCntQ <= '0;
      tickCntQ <= '0;
      busyQ    <= 1'b1;
      doneQ    <= 1'b0;
      pausedQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (busyQ) begin
        if (pauseStb)       pausedQ <= 1'b1;
        else if (resumeStb) pausedQ <= 1'b0;
      end
      if (active) begin
        if (lastEntry) begin
          busyQ   <= 1'b0;
          doneQ   <= 1'b1;
          pausedQ <= 1'b0;
        end else if (zeroSteps) begin
          idxQ     <= idxQ + 1'b1;
          stepCntQ <= '0;
          tickCntQ <= '0;
        end else if (periodTick) begin
          if (tickHit) begin
            tickCntQ <= '0;
            if (stepCntQ + 1'b1 == entry.stepNum) begin
              stepCntQ <= '0;
              idxQ     <= idxQ + 1'b1;
            end else begin
              stepCntQ <= stepCntQ + 1'b1;
            end
          end else begin
            tickCntQ <= tickCntQ + 1'b1;
          end
        end
      end
    end
  end

  assign entryIdx = idxQ[AW-1:0];
  assign busy     = busyQ;
  assign done     = doneQ;
  assign paused   = pausedQ;
endmodule

// File: rtl/gfade_datapath.sv
module gfade_datapath
  import gfade_pkg::*;
#(
  parameter int DUTY_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  gfade_strobe_t     strb,
  input  logic [DUTY_W-1:0] dutyInit,
  output logic [DUTY_W-1:0] duty
);
  localparam logic [DUTY_W:0] DUTY_MAX = {1'b0, {DUTY_W{1'b1}}};

  logic [DUTY_W-1:0] dutyQ, dutyNext;
  logic [DUTY_W:0]   sumUp;
  logic [DUTY_W-1:0] sizeExt;

  always_comb begin
    sizeExt = DUTY_W'(strb.stepSize);
    sumUp   = {1'b0, dutyQ} + {1'b0, sizeExt};
    if (strb.stepUp)
      dutyNext = (sumUp > DUTY_MAX) ? DUTY_MAX[DUTY_W-1:0] : sumUp[DUTY_W-1:0];
    else
      dutyNext = (dutyQ < sizeExt) ? '0 : dutyQ - sizeExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dutyQ <= '0;
    else if (strb.loadInit) dutyQ <= dutyInit;
    else if (strb.stepEn)   dutyQ <= dutyNext;
  end

  assign duty = dutyQ;
endmodule

// File: rtl/gamma_fade_engine.sv
module gamma_fade_engine
  import gfade_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int DUTY_W  = 20,
  localparam int AW    = $clog2(ENTRIES),
  localparam int CNT_W = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ramWrEn,
  input  logic [AW-1:0]     ramWrAddr,
  input  logic [31:0]       ramWrData,
  input  logic [CNT_W-1:0]  entryCount,
  input  logic [DUTY_W-1:0] dutyInit,
  input  logic              startSet,
  input  logic              pauseStb,
  input  logic              resumeStb,
  input  logic              periodTick,
  output logic [DUTY_W-1:0] dutyOut,
  output logic              fadeBusy,
  output logic              fadeDone
);
  gfade_entry_t  curEntry;
  gfade_strobe_t strb;
  logic [AW-1:0] rdIdx;
  logic          pausedQ;
  logic          stepEnW, stepUpW;

  gfade_param_ram #(.ENTRIES(ENTRIES)) ram_i (
    .clk(clk), .rstN(rstN), .wrEn(ramWrEn), .wrAddr(ramWrAddr),
    .wrData(ramWrData), .rdAddr(rdIdx), .rdEntry(curEntry)
  );

  gfade_ctrl #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk(clk), .rstN(rstN), .entryCount(entryCount), .startSet(startSet),
    .pauseStb(pauseStb), .resumeStb(resumeStb), .periodTick(periodTick),
    .entry(curEntry), .entryIdx(rdIdx), .strb(strb), .busy(fadeBusy),
    .done(fadeDone), .paused(pausedQ)
  );

  gfade_datapath #(.DUTY_W(DUTY_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .dutyInit(dutyInit), .duty(dutyOut)
  );

  assign stepEnW = strb.stepEn;
  assign stepUpW = strb.stepUp;
endmodule

// File: rtl/gfade_checker.sv
module gfade_checker #(
  parameter int DUTY_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              startSet,
  input logic              resumeStb,
  input logic [DUTY_W-1:0] dutyInit,
  input logic [DUTY_W-1:0] dutyOut,
  input logic              fadeBusy,
  input logic              fadeDone,
  input logic              paused,
  input logic              stepEn,
  input logic              stepUp
);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fadeBusy && !startSet) |=> $stable(dutyOut));

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    startSet |=> (fadeBusy && dutyOut == $past(dutyInit)));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    fadeDone |-> !fadeBusy);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    fadeDone |=> !fadeDone);

  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fadeBusy) |-> fadeDone);

  // R7
  up_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && stepUp) |=> dutyOut >= $past(dutyOut));

  // R8
  down_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !stepUp) |=> dutyOut <= $past(dutyOut));

  // R9
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (paused && !resumeStb && !startSet) |=> $stable(dutyOut));
endmodule

bind gamma_fade_engine gfade_checker #(.DUTY_W(DUTY_W)) chk_i (
  .clk(clk), .rstN(rstN), .startSet(startSet), .resumeStb(resumeStb),
  .dutyInit(dutyInit), .dutyOut(dutyOut), .fadeBusy(fadeBusy),
  .fadeDone(fadeDone), .paused(pausedQ), .stepEn(stepEnW), .stepUp(stepUpW)
);

// File: tb/gamma_fade_engine_tb_top.sv
`timescale 1ns/1ps
module gamma_fade_engine_tb_top;
  localparam int DUTY_W = 20;
  localparam int DMAX   = (1 << DUTY_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ramWrEn = 1'b0;
  logic [3:0]        ramWrAddr = '0;
  logic [31:0]       ramWrData = '0;
  logic [4:0]        entryCount = '0;
  logic [DUTY_W-1:0] dutyInit = '0;
  logic              startSet = 1'b0;
  logic              pauseStb = 1'b0;
  logic              resumeStb = 1'b0;
  logic              periodTick = 1'b0;
  logic [DUTY_W-1:0] dutyOut;
  logic              fadeBusy, fadeDone;

  int testCnt = 0;
  int failCnt = 0;

  always #2.5 clk = ~clk;

  gamma_fade_engine dut_i (
    .clk(clk), .rstN(rstN), .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr),
    .ramWrData(ramWrData), .entryCount(entryCount), .dutyInit(dutyInit),
    .startSet(startSet), .pauseStb(pauseStb), .resumeStb(resumeStb),
    .periodTick(periodTick), .dutyOut(dutyOut), .fadeBusy(fadeBusy),
    .fadeDone(fadeDone)
  );

  task automatic check(input string tag, input int actual, input int expected);
    testCnt++;
    if (actual != expected) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic writeEntry(input int idx, input bit up, input int cyc,
                            input int scale, input int num);
    ramWrEn   = 1'b1;
    ramWrAddr = 4'(idx);
    ramWrData = {1'b0, 10'(num), 10'(scale), 10'(cyc), up};
    @(negedge clk);
    ramWrEn = 1'b0;
  endtask

  task automatic startFade(input int init, input int cnt);
    dutyInit   = DUTY_W'(init);
    entryCount = 5'(cnt);
    startSet   = 1'b1;
    @(negedge clk);
    startSet = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      periodTick = 1'b1;
      @(negedge clk);
    end
    periodTick = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset duty", int'(dutyOut), 0);
    check("R1 reset busy", int'(fadeBusy), 0);
    check("R1 reset done", int'(fadeDone), 0);
    ticks(3);
    check("R1 idle duty hold", int'(dutyOut), 0);
  endtask

  task automatic t_rise();
    writeEntry(0, 1'b1, 2, 5, 3);
    startFade(100, 1);
    check("R2 start loads duty", int'(dutyOut), 100);
    check("R2 start sets busy", int'(fadeBusy), 1);
    ticks(1);
    check("R3 no step before interval", int'(dutyOut), 100);
    ticks(1);
    check("R3 first rise", int'(dutyOut), 105);
    ticks(4);
    check("R3 third rise", int'(dutyOut), 115);
    check("R6 busy before end", int'(fadeBusy), 1);
    @(negedge clk);
    check("R6 busy cleared", int'(fadeBusy), 0);
    check("R6 done pulse", int'(fadeDone), 1);
    @(negedge clk);
    check("R6 done one cycle", int'(fadeDone), 0);
    ticks(4);
    check("R6 duty held after end", int'(dutyOut), 115);
  endtask

  task automatic t_chain();
    writeEntry(0, 1'b0, 1, 10, 2);
    writeEntry(1, 1'b1, 3, 99, 0);
    writeEntry(2, 1'b1, 0, 3, 2);
    startFade(500, 3);
    ticks(1);
    check("R4 first fall", int'(dutyOut), 490);
    ticks(1);
    check("R4 second fall", int'(dutyOut), 480);
    @(negedge clk);
    check("R5 zero-step word no change", int'(dutyOut), 480);
    ticks(1);
    check("R12 interval 0 steps each tick", int'(dutyOut), 483);
    ticks(1);
    check("R5 next word applied", int'(dutyOut), 486);
    @(negedge clk);
    check("R5 chain ends", int'(fadeDone), 1);
  endtask

  task automatic t_saturate();
    writeEntry(0, 1'b1, 1, 1000, 2);
    startFade(DMAX - 575, 1);
    ticks(1);
    check("R7 clamp at max", int'(dutyOut), DMAX);
    ticks(1);
    check("R7 stays at max", int'(dutyOut), DMAX);
    @(negedge clk);
    writeEntry(0, 1'b0, 1, 1000, 2);
    startFade(1500, 1);
    ticks(1);
    check("R8 fall", int'(dutyOut), 500);
    ticks(1);
    check("R8 clamp at zero", int'(dutyOut), 0);
    @(negedge clk);
  endtask

  task automatic t_pause();
    writeEntry(0, 1'b1, 3, 7, 2);
    startFade(0, 1);
    ticks(1);
    pauseStb   = 1'b1;
    periodTick = 1'b1;
    @(negedge clk);
    pauseStb   = 1'b0;
    periodTick = 1'b0;
    check("R9 tick with pause ignored", int'(dutyOut), 0);
    ticks(5);
    check("R9 paused duty holds", int'(dutyOut), 0);
    check("R9 still busy while paused", int'(fadeBusy), 1);
    resumeStb  = 1'b1;
    periodTick = 1'b1;
    @(negedge clk);
    resumeStb  = 1'b0;
    periodTick = 1'b0;
    check("R10 tick with resume counted", int'(dutyOut), 0);
    ticks(1);
    check("R10 resumes partial count", int'(dutyOut), 7);
    ticks(3);
    check("R10 second step", int'(dutyOut), 14);
    @(negedge clk);
    check("R10 fade completes", int'(fadeDone), 1);
  endtask

  task automatic t_empty();
    startFade(77, 0);
    check("R11 busy after start", int'(fadeBusy), 1);
    @(negedge clk);
    check("R11 ends at once", int'(fadeDone), 1);
    check("R11 duty kept", int'(dutyOut), 77);
    check("R11 busy cleared", int'(fadeBusy), 0);
  endtask

  initial begin
    #(200000 * 5);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_chain();
    t_saturate();
    t_pause();
    t_empty();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule